// File: doc/BRIEF.md
# Trap Entry Mode and Handler Vector Generator

This block takes a trap request and decides how the processor enters its handler. It weighs the current nesting depth of traps and the hyperprivileged red-state flag against two nesting limits and a requested target privilege level. It then picks one of four entry modes: reset-error, error, hyperprivileged or privileged. It also forms the handler fetch address and the two sequential fetch addresses after it.

The block also reports which privilege level the core was running at when the trap arrived, decoded from the two status words. Saving the architectural state and choosing the target level are done elsewhere. The target level comes in as an input.

The block samples its inputs on a one-cycle request strobe. All results are registered and appear, with a one-cycle valid pulse, on the clock edge after the strobe. Between requests the results hold their last values.

Top module: `trap_dispatch`

## Requirements
- R1: `cur_lvl_o` reports the level at the moment of the request: 0 (user) when `pstate_i[2]` is 0; 1 (privileged) when `pstate_i[2]` is 1 and `hpstate_i[2]` is 0; 2 (hyperprivileged) when both bits are 1. The value 3 never appears.
- R2: When `hpstate_i[5]` is 1, or `tl_i` equals MAX_TL-1 (5 by default), the mode is reset-error (`mode_o` = 4'b0001). `pc_o` is then 0xFFFFFFFFF00000A0 and `tt_o` is `tt_i`. This case overrides every other case.
- R3: Otherwise, when `tl_i` is MAX_TL or greater, the mode is error (`mode_o` = 4'b0010) and `tt_o` is `tt_i`. `pc_o`, `npc_o` and `nnpc_o` keep the values they had before the request.
- R4: Otherwise, when `tl_i` exceeds MAX_PTL (2 by default) and `target_lvl_i` is 1, the trap is redirected. The mode is hyperprivileged (`mode_o` = 4'b0100), `tt_o` is 2, and `pc_o` is the hyperprivileged vector built with trap type 2.
- R5: Otherwise, when `target_lvl_i` is 2 or 3, the mode is hyperprivileged and `tt_o` is `tt_i`. `pc_o` is `htba_i` with bits 13:0 cleared, OR `tt_i` shifted left by 5 and kept to bits 13:0.
- R6: Otherwise (target 0 or 1), the mode is privileged (`mode_o` = 4'b1000) and `tt_o` is `tt_i`. `pc_o` is `tba_i` with bits 14:0 cleared, OR bit 14 set when `tl_i`+1 is greater than 1, OR `tt_i` shifted left by 5 and kept to bits 13:0.
- R7: In every mode except error, `npc_o` equals `pc_o`+4 and `nnpc_o` equals `npc_o`+4, both modulo 2^64.
- R8: Results update, with `valid_o` high for exactly one cycle, on the clock edge after a cycle in which `trap_valid_i` is high. `mode_o` then has exactly one bit set. In cycles with no request, `valid_o` is 0 and every result holds.
- R9: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Request strobe, one cycle per trap |
| pstate_i | input | 13 | Processor status word |
| hpstate_i | input | 11 | Hyperprivileged status word |
| tl_i | input | 3 | Current trap nesting depth |
| tt_i | input | 9 | Trap type of the request |
| tba_i | input | 64 | Privileged trap table base |
| htba_i | input | 64 | Hyperprivileged trap table base |
| target_lvl_i | input | 2 | Requested handler level: 0 user, 1 privileged, 2 or 3 hyperprivileged |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| mode_o | output | 4 | One-hot entry mode: bit0 reset-error, bit1 error, bit2 hyperprivileged, bit3 privileged |
| tt_o | output | 9 | Trap type to record |
| pc_o | output | 64 | Handler fetch address |
| npc_o | output | 64 | Next fetch address |
| nnpc_o | output | 64 | Fetch address after next |
| cur_lvl_o | output | 2 | Level the core was at when the trap arrived |

## Verification
A fault in the priority chain shows on the first result after the request that triggers it, one cycle after the strobe. It appears as the wrong `mode_o` bit, together with a `tt_o` or `pc_o` from the wrong table. A slip in the vector arithmetic shows in the same cycle as stray or missing bits in `pc_o` or `npc_o`. The bench uses all-ones bases and the largest trap type to expose any masking error. A stale or wrongly loaded result register shows as a change in the outputs during an idle cycle, or as an error-mode result whose address does not match the previous result.

// File: rtl/trap_dispatch_pkg.sv
package trap_dispatch_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_PRIV  = 2'd1,
    LVL_HYPER = 2'd2
  } lvl_e;

  localparam int MODE_N     = 4;
  localparam int MODE_RSTER = 0;
  localparam int MODE_ERR   = 1;
  localparam int MODE_HYP   = 2;
  localparam int MODE_PRV   = 3;

endpackage

// File: rtl/trap_level_decode.sv
module trap_level_decode
  import trap_dispatch_pkg::*;
#(
  parameter int PS_W    = 13,
  parameter int HPS_W   = 11,
  parameter int PRIV_BIT = 2,
  parameter int HPRIV_BIT = 2
) (
  input  logic [PS_W-1:0]  pstate,
  input  logic [HPS_W-1:0] hpstate,
  output lvl_e             level
);

  always_comb begin
    if (!pstate[PRIV_BIT])       level = LVL_USER;
    else if (!hpstate[HPRIV_BIT]) level = LVL_PRIV;
    else                          level = LVL_HYPER;
  end

  always_comb begin
    AST_LEVEL_LEGAL: assert (level != 2'd3); // R1
  end

endmodule

// File: rtl/trap_mode_select.sv
module trap_mode_select
  import trap_dispatch_pkg::*;
#(
  parameter int TL_W    = 3,
  parameter int TT_W    = 9,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int WDOG_TT = 2
) (
  input  logic              red_flag,
  input  logic [TL_W-1:0]   tl,
  input  logic [1:0]        target,
  input  logic [TT_W-1:0]   tt_in,
  output logic [MODE_N-1:0] mode,
  output logic [TT_W-1:0]   tt_eff,
  output logic              raised
);

  localparam logic [TL_W-1:0] TL_TOP  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_EDGE = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_PRV  = TL_W'(MAX_PTL);
  localparam logic [TT_W-1:0] TT_WDOG = TT_W'(WDOG_TT);

  logic take_rster, take_err, take_wdog, take_hyp;

  assign take_rster = red_flag || (tl == TL_EDGE);
  assign take_err   = (tl >= TL_TOP);
  assign take_wdog  = (tl > TL_PRV) && (target == LVL_PRIV);
  assign take_hyp   = target[1];
  // the new depth is tl+1; it exceeds 1 whenever tl is non-zero
  assign raised     = (tl != '0);

  always_comb begin
    mode   = '0;
    tt_eff = tt_in;
    if (take_rster) begin
      mode[MODE_RSTER] = 1'b1;
    end else if (take_err) begin
      mode[MODE_ERR] = 1'b1;
    end else if (take_wdog) begin
      mode[MODE_HYP] = 1'b1;
      tt_eff         = TT_WDOG;
    end else if (take_hyp) begin
      mode[MODE_HYP] = 1'b1;
    end else begin
      mode[MODE_PRV] = 1'b1;
    end
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($countones(mode) == 1); // R8
  end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_dispatch_pkg::*;
#(
  parameter int          AW         = 64,
  parameter int          TT_W       = 9,
  parameter int          HVEC_BITS  = 14,
  parameter int          TT_SHIFT   = 5,
  parameter int          INST_BYTES = 4,
  parameter logic [63:0] RST_BASE   = 64'hFFFF_FFFF_F000_0000,
  parameter logic [63:0] RST_OFF    = 64'h0000_0000_0000_00A0
) (
  input  logic [MODE_N-1:0] mode,
  input  logic [TT_W-1:0]   tt_eff,
  input  logic              raised,
  input  logic [AW-1:0]     tba,
  input  logic [AW-1:0]     htba,
  output logic [AW-1:0]     pc,
  output logic [AW-1:0]     npc,
  output logic [AW-1:0]     nnpc
);

  localparam logic [AW-1:0] MASK_H = (AW'(1) << HVEC_BITS) - AW'(1);
  localparam logic [AW-1:0] MASK_P = (AW'(1) << (HVEC_BITS + 1)) - AW'(1);
  localparam logic [AW-1:0] RAISE  = AW'(1) << HVEC_BITS;
  localparam logic [AW-1:0] STEP   = AW'(INST_BYTES);

  function automatic logic [AW-1:0] tt_slot(input logic [TT_W-1:0] t);
    return (AW'(t) << TT_SHIFT) & MASK_H;
  endfunction

  function automatic logic [AW-1:0] hyp_vec(input logic [AW-1:0] b,
                                            input logic [TT_W-1:0] t);
    return (b & ~MASK_H) | tt_slot(t);
  endfunction

  function automatic logic [AW-1:0] prv_vec(input logic [AW-1:0] b,
                                            input logic [TT_W-1:0] t,
                                            input logic r);
    return (b & ~MASK_P) | (r ? RAISE : '0) | tt_slot(t);
  endfunction

  function automatic logic [AW-1:0] next_fetch(input logic [AW-1:0] a);
    return a + STEP;
  endfunction

  always_comb begin
    if (mode[MODE_RSTER])    pc = AW'(RST_BASE | RST_OFF);
    else if (mode[MODE_HYP]) pc = hyp_vec(htba, tt_eff);
    else                     pc = prv_vec(tba, tt_eff, raised);
  end

  assign npc  = next_fetch(pc);
  assign nnpc = next_fetch(npc);

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_dispatch_pkg::*;
#(
  parameter int AW      = 64,
  parameter int PS_W    = 13,
  parameter int HPS_W   = 11,
  parameter int TL_W    = 3,
  parameter int TT_W    = 9,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int RED_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid_i,
  input  logic [PS_W-1:0]   pstate_i,
  input  logic [HPS_W-1:0]  hpstate_i,
  input  logic [TL_W-1:0]   tl_i,
  input  logic [TT_W-1:0]   tt_i,
  input  logic [AW-1:0]     tba_i,
  input  logic [AW-1:0]     htba_i,
  input  logic [1:0]        target_lvl_i,
  output logic              valid_o,
  output logic [MODE_N-1:0] mode_o,
  output logic [TT_W-1:0]   tt_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     npc_o,
  output logic [AW-1:0]     nnpc_o,
  output logic [1:0]        cur_lvl_o
);

  localparam logic [AW-1:0] RST_PC = AW'(64'hFFFF_FFFF_F000_00A0);
  localparam logic [AW-1:0] STEP   = AW'(4);

  lvl_e              lvl_now;
  logic [MODE_N-1:0] sel_mode;
  logic [TT_W-1:0]   sel_tt;
  logic              sel_raised;
  logic [AW-1:0]     vec_pc, vec_npc, vec_nnpc;
  logic              take_new_pc;

  trap_level_decode #(.PS_W(PS_W), .HPS_W(HPS_W)) u_lvl (
    .pstate  (pstate_i),
    .hpstate (hpstate_i),
    .level   (lvl_now)
  );

  trap_mode_select #(
    .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
  ) u_sel (
    .red_flag (hpstate_i[RED_BIT]),
    .tl       (tl_i),
    .target   (target_lvl_i),
    .tt_in    (tt_i),
    .mode     (sel_mode),
    .tt_eff   (sel_tt),
    .raised   (sel_raised)
  );

  trap_vector_gen #(.AW(AW), .TT_W(TT_W)) u_vec (
    .mode   (sel_mode),
    .tt_eff (sel_tt),
    .raised (sel_raised),
    .tba    (tba_i),
    .htba   (htba_i),
    .pc     (vec_pc),
    .npc    (vec_npc),
    .nnpc   (vec_nnpc)
  );

  assign take_new_pc = trap_valid_i && !sel_mode[MODE_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      mode_o    <= '0;
      tt_o      <= '0;
      cur_lvl_o <= '0;
    end else begin
      valid_o <= trap_valid_i;
      if (trap_valid_i) begin
        mode_o    <= sel_mode;
        tt_o      <= sel_tt;
        cur_lvl_o <= lvl_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o   <= '0;
      npc_o  <= '0;
      nnpc_o <= '0;
    end else if (take_new_pc) begin
      pc_o   <= vec_pc;
      npc_o  <= vec_npc;
      nnpc_o <= vec_nnpc;
    end
  end

  AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $countones(mode_o) == 1); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(pc_o) && $stable(mode_o) && $stable(tt_o)); // R8
  AST_ERR_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && mode_o[MODE_ERR] |-> $stable(pc_o) && $stable(npc_o)); // R3
  AST_RSTER_PC: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && mode_o[MODE_RSTER] |-> pc_o == RST_PC); // R2
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !mode_o[MODE_ERR] |-> npc_o == pc_o + STEP && nnpc_o == npc_o + STEP); // R7
  AST_LVL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl_o != 2'd3); // R1

endmodule

// File: tb/trap_dispatch_tb.sv
module trap_dispatch_tb;

  typedef struct packed {
    logic [3:0]  mode;
    logic [8:0]  tt;
    logic [63:0] pc;
    logic [1:0]  lvl;
    logic [7:0]  req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid_i = 1'b0;
  logic [12:0] pstate_i = '0;
  logic [10:0] hpstate_i = '0;
  logic [2:0]  tl_i = '0;
  logic [8:0]  tt_i = '0;
  logic [63:0] tba_i = '0;
  logic [63:0] htba_i = '0;
  logic [1:0]  target_lvl_i = '0;
  logic        valid_o;
  logic [3:0]  mode_o;
  logic [8:0]  tt_o;
  logic [63:0] pc_o, npc_o, nnpc_o;
  logic [1:0]  cur_lvl_o;

  int checks = 0;
  int failures = 0;
  exp_t q[$];
  logic [63:0] model_pc = '0;
  logic [63:0] seen_pc = '0;
  logic [3:0]  seen_mode = '0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  trap_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid_i),
    .pstate_i(pstate_i), .hpstate_i(hpstate_i), .tl_i(tl_i), .tt_i(tt_i),
    .tba_i(tba_i), .htba_i(htba_i), .target_lvl_i(target_lvl_i),
    .valid_o(valid_o), .mode_o(mode_o), .tt_o(tt_o), .pc_o(pc_o),
    .npc_o(npc_o), .nnpc_o(nnpc_o), .cur_lvl_o(cur_lvl_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model of the entry decision, written from the requirements
  task automatic drive(input logic [12:0] ps, input logic [10:0] hps, input logic [2:0] tl,
                       input logic [8:0] tt, input logic [63:0] tba, input logic [63:0] htba,
                       input logic [1:0] tgt, input logic [7:0] req, input bit gap);
    exp_t e;
    logic [63:0] hslot;
    e.req = req;
    e.lvl = !ps[2] ? 2'd0 : (!hps[2] ? 2'd1 : 2'd2);
    e.tt  = tt;
    if (hps[5] || tl == 3'd5) begin
      e.mode = 4'b0001; e.pc = 64'hFFFFFFFFF00000A0;
    end else if (tl >= 3'd6) begin
      e.mode = 4'b0010; e.pc = model_pc;
    end else if (tl > 3'd2 && tgt == 2'd1) begin
      e.mode = 4'b0100; e.tt = 9'd2;
      e.pc = {htba[63:14], 14'd0} + 64'd64;
    end else if (tgt >= 2'd2) begin
      hslot = {50'd0, tt, 5'd0};
      e.mode = 4'b0100; e.pc = {htba[63:14], 14'd0} + hslot;
    end else begin
      hslot = {50'd0, tt, 5'd0};
      e.mode = 4'b1000;
      e.pc = {tba[63:15], 15'd0} + hslot + ((tl + 4'd1 > 4'd1) ? 64'h4000 : 64'd0);
    end
    model_pc = e.pc;
    q.push_back(e);
    @(negedge clk);
    pstate_i = ps; hpstate_i = hps; tl_i = tl; tt_i = tt;
    tba_i = tba; htba_i = htba; target_lvl_i = tgt; trap_valid_i = 1'b1;
    @(negedge clk);
    trap_valid_i = 1'b0;
    // scramble inputs while idle: results must not follow them
    tt_i = ~tt_i; tba_i = ~tba_i; htba_i = ~htba_i;
    if (gap) @(negedge clk);
  endtask

  // monitor: compare each result with the queued expectation
  initial begin
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #0.5;
      if (valid_o) begin
        if (q.size() == 0) begin
          check("R8 unexpected valid", 64'd1, 64'd0);
        end else begin
          e = q.pop_front();
          check($sformatf("R8 mode req%0d", e.req), {60'd0, mode_o}, {60'd0, e.mode});
          check($sformatf("R2-6 tt req%0d R4", e.req), {55'd0, tt_o}, {55'd0, e.tt});
          check($sformatf("R2 R3 R5 R6 pc req%0d", e.req), pc_o, e.pc);
          check($sformatf("R7 npc req%0d", e.req), npc_o, e.pc + 64'd4);
          check($sformatf("R7 nnpc req%0d", e.req), nnpc_o, e.pc + 64'd8);
          check($sformatf("R1 level req%0d", e.req), {62'd0, cur_lvl_o}, {62'd0, e.lvl});
          seen_pc = e.pc; seen_mode = e.mode;
        end
      end else begin
        check("R8 idle hold pc", pc_o, seen_pc);
        check("R8 idle hold mode", {60'd0, mode_o}, {60'd0, seen_mode});
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] ones = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", {63'd0, valid_o}, 64'd0);
    check("R9 mode", {60'd0, mode_o}, 64'd0);
    check("R9 pc", pc_o, 64'd0);
    check("R9 nnpc", nnpc_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", pc_o | npc_o | {55'd0, tt_o}, 64'd0);

    // R6 privileged, depth 0, user level, target user
    drive(13'h000, 11'h000, 3'd0, 9'h041, 64'h1234_5678_9ABC_DEF0, 64'h0, 2'd0, 1, 1);
    // R6 privileged with raised flag, priv level
    drive(13'h004, 11'h000, 3'd1, 9'h1FF, ones, ones, 2'd1, 2, 1);
    drive(13'h004, 11'h000, 3'd2, 9'h0AA, 64'h0000_0000_0001_7FFF, 64'h0, 2'd1, 3, 0);
    // R5 hyperprivileged target, hyper level, all-ones base
    drive(13'h004, 11'h004, 3'd3, 9'h1FF, 64'h0, ones, 2'd2, 4, 0);
    drive(13'h000, 11'h004, 3'd0, 9'h123, 64'h0, 64'hABCD_0000_0000_3FFF, 2'd3, 5, 1);
    // R4 watchdog redirect
    drive(13'h004, 11'h000, 3'd3, 9'h077, ones, 64'hAAAA_5555_0000_C000, 2'd1, 6, 1);
    drive(13'h004, 11'h000, 3'd4, 9'h100, ones, ones, 2'd1, 7, 0);
    // R2 reset-error via red flag, via depth edge, and over error depth
    drive(13'h004, 11'h020, 3'd0, 9'h033, ones, ones, 2'd1, 8, 1);
    drive(13'h004, 11'h004, 3'd5, 9'h044, ones, ones, 2'd2, 9, 1);
    drive(13'h000, 11'h024, 3'd6, 9'h055, ones, ones, 2'd0, 10, 1);
    // R6 target set before error: establish a pc, then R3 error holds it
    drive(13'h004, 11'h000, 3'd1, 9'h0C3, 64'h8000_0000_0000_0000, 64'h0, 2'd0, 11, 1);
    drive(13'h004, 11'h004, 3'd6, 9'h1AB, ones, ones, 2'd2, 12, 1);
    drive(13'h000, 11'h000, 3'd7, 9'h00F, ones, ones, 2'd1, 13, 0);
    // R8 back-to-back after error
    drive(13'h004, 11'h004, 3'd2, 9'h002, 64'h0, 64'h5000_0000_0000_0000, 2'd2, 14, 0);
    drive(13'h004, 11'h000, 3'd2, 9'h010, 64'hFFFF_0000_0000_0000, 64'h0, 2'd1, 15, 1);

    repeat (4) @(negedge clk);
    check("R8 queue drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule